// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits in front of the per-core pending state of an interrupt controller. It decides whether an incoming software-generated interrupt (SGI) request may set the pending bit of one of sixteen SGIs. Each request names the target SGI, a requested group (Group 0 or Secure Group 1) and whether it came from the non-secure world. The filter compares the request with the resolved group of the target interrupt and with a 2-bit non-secure access level held for each SGI. A security-disable input (`ds`) turns the non-secure privilege rules off.

The accept or drop decision is combinational. Accepted requests appear one clock later as a one-cycle set-pending strobe on a 32-bit vector, together with a pulse that asks the priority logic to re-evaluate. A second input lets a peripheral interrupt source set pending for IDs 16 to 31 without any filtering. A peripheral ID below 16 is ignored and flagged with an error pulse. The access levels live in a small register inside the block. Only secure writes made while `ds` is low can update it.

Top module: `sgi_accept_filter`

## Requirements
- R1: A request for Secure Group 1 whose target resolves to Group 0 (group code 2'b00) is handled as a Group 0 request and, if it comes from the secure world, is accepted.
- R2: A request handled as Group 0 is dropped when the target's resolved group is not Group 0 (codes 2'b01 Secure Group 1, 2'b10 and 2'b11 non-secure Group 1).
- R3: With `sgi_nonsec`=1 and `ds`=0, a request to a Group 0 target is dropped when the target's access level is 0 and accepted when it is 1 or more.
- R4: With `sgi_nonsec`=1 and `ds`=0, a request to a Secure Group 1 target is dropped when the target's access level is below 2.
- R5: When `ds`=1 or the request is secure, the access level has no effect. A non-secure Group 1 target never depends on it.
- R6: SGI n's access level occupies `nsac_view[2n+1:2n]`. It changes only on a cycle where `nsac_wr`=1, `nsac_wr_sec`=1 and `ds`=0, and then takes `nsac_wdata[2n+1:2n]`.
- R7: An accepted SGI request makes `set_pend[id]` high for exactly the next cycle, with `rescan` high in that same cycle.
- R8: A peripheral request with `ppi_id` in 16..31 makes `set_pend[ppi_id]` high for the next cycle, with `rescan`, whatever happens on the SGI side.
- R9: A peripheral request with `ppi_id` below 16 sets no pending bit and gives a one-cycle `ppi_err` pulse on the next cycle.
- R10: `sgi_accept` and `sgi_drop` are combinational. Exactly one of them is high while `sgi_valid`=1, and both are low otherwise.
- R11: After reset, `set_pend`, `rescan`, `ppi_err` and all access levels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds | input | 1 | Security disable; 1 turns non-secure privilege checks off |
| sgi_grp | input | 32 | Resolved group, 2 bits per SGI at bits [2n+1:2n] |
| sgi_valid | input | 1 | SGI request present |
| sgi_id | input | 4 | Target SGI |
| sgi_req_g1s | input | 1 | Requested group: 0 Group 0, 1 Secure Group 1 |
| sgi_nonsec | input | 1 | Request comes from the non-secure world |
| ppi_valid | input | 1 | Peripheral set-pending request present |
| ppi_id | input | 5 | Peripheral interrupt ID |
| nsac_wr | input | 1 | Access level register write |
| nsac_wr_sec | input | 1 | The write is a secure access |
| nsac_wdata | input | 32 | Access level write data, 2 bits per SGI |
| sgi_accept | output | 1 | Current SGI request accepted |
| sgi_drop | output | 1 | Current SGI request dropped |
| set_pend | output | 32 | One-cycle set-pending strobe per interrupt ID |
| rescan | output | 1 | Re-evaluate highest-priority pending interrupt |
| ppi_err | output | 1 | Peripheral ID outside 16..31 seen |
| nsac_view | output | 32 | Current access levels |

## Verification
The hardest case to reach is a non-secure request that lands exactly on an access-level threshold. That means a Group 0 target at level 0 against 1, and a Secure Group 1 target at level 1 against 2. Each of these needs a secure write made while `ds` is low before the request can even be tested. The stimulus first performs those writes in a fixed order and then fires the request. It also tries non-secure writes and writes made with `ds` high, and confirms that they leave the levels alone. A long random phase then mixes group maps, `ds` toggles, writes and simultaneous peripheral requests, so thresholds are also crossed in combinations nobody planned.

// File: rtl/sgif_pkg.sv
package sgif_pkg;
  typedef enum logic [1:0] {
    GRP_SEC0  = 2'b00,
    GRP_SEC1  = 2'b01,
    GRP_NS1   = 2'b10,
    GRP_NS1B  = 2'b11
  } grp_e;

  localparam int unsigned GRP_W = 2;
  localparam int unsigned LVL_W = 2;
endpackage

// File: rtl/sgif_nsac_regs.sv
module sgif_nsac_regs #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned VEC_W  = NUM_SGI * LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sec,
  input  logic             ds,
  input  logic [VEC_W-1:0] wr_data,
  output logic [VEC_W-1:0] lvl_q
);
  logic             upd_en;
  logic [VEC_W-1:0] lvl_d;

  // secure write while security is enabled is the only update path
  always_comb begin
    upd_en = wr_en && wr_sec && !ds;
    lvl_d  = lvl_q;
    if (upd_en) begin
      lvl_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/sgif_sgi_judge.sv
module sgif_sgi_judge
  import sgif_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned IDW    = $clog2(NUM_SGI)
) (
  input  logic                     req_valid,
  input  logic [IDW-1:0]           req_id,
  input  logic                     req_g1s,
  input  logic                     req_nonsec,
  input  logic                     ds,
  input  logic [NUM_SGI*GRP_W-1:0] grp_vec,
  input  logic [NUM_SGI*LVL_W-1:0] lvl_vec,
  output logic                     accept,
  output logic                     drop,
  output logic [NUM_SGI-1:0]       acc_onehot
);
  logic [NUM_SGI-1:0] ok_vec;

  // per-SGI permission, computed in parallel and then selected by ID
  for (genvar i = 0; i < NUM_SGI; i++) begin : g_sgi
    grp_e             grp;
    logic [LVL_W-1:0] lvl;
    logic             as_g0;
    logic             grp_mismatch;
    logic             priv_fail;

    assign grp          = grp_e'(grp_vec[i*GRP_W +: GRP_W]);
    assign lvl          = lvl_vec[i*LVL_W +: LVL_W];
    // Secure Group 1 asked of a Group 0 interrupt is downgraded
    assign as_g0        = !req_g1s || (grp == GRP_SEC0);
    assign grp_mismatch = as_g0 && (grp != GRP_SEC0);
    assign priv_fail    = req_nonsec && !ds &&
                          (((grp == GRP_SEC0) && (lvl < LVL_W'(1))) ||
                           ((grp == GRP_SEC1) && (lvl < LVL_W'(2))));
    assign ok_vec[i]    = !grp_mismatch && !priv_fail;
  end

  logic ok_sel;

  always_comb begin
    ok_sel     = ok_vec[req_id];
    accept     = req_valid && ok_sel;
    drop       = req_valid && !ok_sel;
    acc_onehot = '0;
    if (accept) begin
      acc_onehot[req_id] = 1'b1;
    end
  end
endmodule

// File: rtl/sgif_ppi_decode.sv
module sgif_ppi_decode #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  localparam int unsigned NUM_ID = NUM_SGI + NUM_PPI,
  localparam int unsigned PIDW   = $clog2(NUM_ID)
) (
  input  logic              ppi_valid,
  input  logic [PIDW-1:0]   ppi_id,
  output logic [NUM_ID-1:0] hit_vec,
  output logic              bad_id
);
  assign hit_vec[NUM_SGI-1:0] = '0;

  for (genvar j = 0; j < NUM_PPI; j++) begin : g_ppi
    assign hit_vec[NUM_SGI+j] = ppi_valid && (ppi_id == PIDW'(NUM_SGI + j));
  end

  assign bad_id = ppi_valid && (ppi_id < PIDW'(NUM_SGI));
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgif_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  localparam int unsigned NUM_ID = NUM_SGI + NUM_PPI,
  localparam int unsigned IDW    = $clog2(NUM_SGI),
  localparam int unsigned PIDW   = $clog2(NUM_ID),
  localparam int unsigned GVW    = NUM_SGI * GRP_W,
  localparam int unsigned LVW    = NUM_SGI * LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ds,
  input  logic [GVW-1:0]    sgi_grp,
  input  logic              sgi_valid,
  input  logic [IDW-1:0]    sgi_id,
  input  logic              sgi_req_g1s,
  input  logic              sgi_nonsec,
  input  logic              ppi_valid,
  input  logic [PIDW-1:0]   ppi_id,
  input  logic              nsac_wr,
  input  logic              nsac_wr_sec,
  input  logic [LVW-1:0]    nsac_wdata,
  output logic              sgi_accept,
  output logic              sgi_drop,
  output logic [NUM_ID-1:0] set_pend,
  output logic              rescan,
  output logic              ppi_err,
  output logic [LVW-1:0]    nsac_view
);
  logic [NUM_SGI-1:0] sgi_hit;
  logic [NUM_ID-1:0]  ppi_hit;
  logic               ppi_bad;

  sgif_nsac_regs #(.NUM_SGI(NUM_SGI), .LVL_W(LVL_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (nsac_wr),
    .wr_sec  (nsac_wr_sec),
    .ds      (ds),
    .wr_data (nsac_wdata),
    .lvl_q   (nsac_view)
  );

  sgif_sgi_judge #(.NUM_SGI(NUM_SGI)) u_judge (
    .req_valid  (sgi_valid),
    .req_id     (sgi_id),
    .req_g1s    (sgi_req_g1s),
    .req_nonsec (sgi_nonsec),
    .ds         (ds),
    .grp_vec    (sgi_grp),
    .lvl_vec    (nsac_view),
    .accept     (sgi_accept),
    .drop       (sgi_drop),
    .acc_onehot (sgi_hit)
  );

  sgif_ppi_decode #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_ppi (
    .ppi_valid (ppi_valid),
    .ppi_id    (ppi_id),
    .hit_vec   (ppi_hit),
    .bad_id    (ppi_bad)
  );

  logic [NUM_ID-1:0] pend_d;
  logic              rescan_d;
  logic              err_d;

  always_comb begin
    pend_d   = {{NUM_PPI{1'b0}}, sgi_hit} | ppi_hit;
    rescan_d = |pend_d;
    err_d    = ppi_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pend <= '0;
      rescan   <= 1'b0;
      ppi_err  <= 1'b0;
    end else begin
      set_pend <= pend_d;
      rescan   <= rescan_d;
      ppi_err  <= err_d;
    end
  end
endmodule

// File: rtl/sgif_chk.sv
module sgif_chk #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  localparam int unsigned NUM_ID = NUM_SGI + NUM_PPI,
  localparam int unsigned IDW    = $clog2(NUM_SGI),
  localparam int unsigned PIDW   = $clog2(NUM_ID)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ds,
  input logic [NUM_SGI*2-1:0] sgi_grp,
  input logic                 sgi_valid,
  input logic [IDW-1:0]       sgi_id,
  input logic                 sgi_nonsec,
  input logic                 ppi_valid,
  input logic [PIDW-1:0]      ppi_id,
  input logic                 nsac_wr,
  input logic                 nsac_wr_sec,
  input logic                 sgi_accept,
  input logic                 sgi_drop,
  input logic [NUM_ID-1:0]    set_pend,
  input logic                 rescan,
  input logic                 ppi_err,
  input logic [NUM_SGI*2-1:0] nsac_view
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sgi_accept && sgi_drop));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sgi_valid |-> (!sgi_accept && !sgi_drop));

  a_r4_sec1_low_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_valid && sgi_nonsec && !ds && (sgi_grp[sgi_id*2 +: 2] == 2'b01) &&
     (nsac_view[sgi_id*2 +: 2] < 2'd2)) |-> sgi_drop);

  a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(nsac_wr && nsac_wr_sec && !ds) |=> $stable(nsac_view));

  a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_valid && sgi_accept) |=> (set_pend[$past(sgi_id)] && rescan));

  a_r7_sgi_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_pend[NUM_SGI-1:0]));

  a_r8_ppi_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ppi_valid && (ppi_id >= PIDW'(NUM_SGI))) |=> (set_pend[$past(ppi_id)] && rescan));

  a_r9_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (ppi_valid && (ppi_id < PIDW'(NUM_SGI))) |=> ppi_err);
endmodule

bind sgi_accept_filter sgif_chk #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ds          (ds),
  .sgi_grp     (sgi_grp),
  .sgi_valid   (sgi_valid),
  .sgi_id      (sgi_id),
  .sgi_nonsec  (sgi_nonsec),
  .ppi_valid   (ppi_valid),
  .ppi_id      (ppi_id),
  .nsac_wr     (nsac_wr),
  .nsac_wr_sec (nsac_wr_sec),
  .sgi_accept  (sgi_accept),
  .sgi_drop    (sgi_drop),
  .set_pend    (set_pend),
  .rescan      (rescan),
  .ppi_err     (ppi_err),
  .nsac_view   (nsac_view)
);

// File: tb/sim_sgi_accept_filter.sv
module sim_sgi_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ds;
  logic [31:0] sgi_grp;
  logic        sgi_valid;
  logic [3:0]  sgi_id;
  logic        sgi_req_g1s;
  logic        sgi_nonsec;
  logic        ppi_valid;
  logic [4:0]  ppi_id;
  logic        nsac_wr;
  logic        nsac_wr_sec;
  logic [31:0] nsac_wdata;
  logic        sgi_accept;
  logic        sgi_drop;
  logic [31:0] set_pend;
  logic        rescan;
  logic        ppi_err;
  logic [31:0] nsac_view;

  always #4 clk = ~clk;

  sgi_accept_filter u0 (.*);

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int lvl_m[16];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_ok(int id, bit rq, bit ns, bit d);
    int  g;
    bit  treat_g0;
    g = int'(sgi_grp[2*id +: 2]);
    treat_g0 = (rq == 1'b0) || (g == 0);
    if (treat_g0 && g != 0) return 1'b0;
    if (ns && !d) begin
      if (g == 0 && lvl_m[id] < 1) return 1'b0;
      if (g == 1 && lvl_m[id] < 2) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] m_lvl_vec();
    logic [31:0] v = '0;
    for (int i = 0; i < 16; i++) v[2*i +: 2] = 2'(lvl_m[i]);
    return v;
  endfunction

  // caller is at a falling edge; returns at the next falling edge
  task automatic step(bit sv, int sid, bit rq, bit ns, bit pv, int pid,
                      bit w, bit wsec, logic [31:0] wd, string tag);
    bit          exp_acc;
    logic [31:0] exp_pend;
    bit          exp_err;
    sgi_valid = sv; sgi_id = 4'(sid); sgi_req_g1s = rq; sgi_nonsec = ns;
    ppi_valid = pv; ppi_id = 5'(pid);
    nsac_wr = w; nsac_wr_sec = wsec; nsac_wdata = wd;
    #1;
    exp_acc = sv && m_ok(sid, rq, ns, ds);
    chk(sgi_accept == exp_acc, {tag, " R10"}, "sgi_accept", sgi_accept, exp_acc);
    chk(sgi_drop == (sv && !exp_acc), {tag, " R10"}, "sgi_drop", sgi_drop, sv && !exp_acc);
    exp_pend = '0;
    if (exp_acc) exp_pend[sid] = 1'b1;
    if (pv && pid >= 16) exp_pend[pid] = 1'b1;
    exp_err = pv && pid < 16;
    @(posedge clk);
    if (w && wsec && !ds) for (int i = 0; i < 16; i++) lvl_m[i] = int'(wd[2*i +: 2]);
    @(negedge clk);
    chk(set_pend == exp_pend, {tag, " R7 R8"}, "set_pend", set_pend, exp_pend);
    chk(rescan == (exp_pend != 0), {tag, " R7"}, "rescan", rescan, exp_pend != 0);
    chk(ppi_err == exp_err, {tag, " R9"}, "ppi_err", ppi_err, exp_err);
    chk(nsac_view == m_lvl_vec(), {tag, " R6"}, "nsac_view", nsac_view, m_lvl_vec());
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) lvl_m[i] = 0;
    rst_n = 1'b0; ds = 1'b0;
    // id0 Group 0, id1 Secure Group 1, id2 NS Group 1, id3 code 11
    sgi_grp = 32'h0000_00E4;
    sgi_valid = 0; sgi_id = 0; sgi_req_g1s = 0; sgi_nonsec = 0;
    ppi_valid = 0; ppi_id = 0; nsac_wr = 0; nsac_wr_sec = 0; nsac_wdata = '0;
    repeat (3) @(negedge clk);
    chk(set_pend == 0 && !rescan && !ppi_err, "R11", "outputs in reset",
        {set_pend, rescan, ppi_err}, 0);
    chk(nsac_view == 0, "R11", "levels in reset", nsac_view, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R11 idle");

    step(1, 0, 1, 0, 0, 0, 0, 0, '0, "R1 downgrade secure");
    step(1, 1, 0, 0, 0, 0, 0, 0, '0, "R2 g0 req to sec1");
    step(1, 2, 0, 0, 0, 0, 0, 0, '0, "R2 g0 req to ns1");
    step(1, 3, 0, 0, 0, 0, 0, 0, '0, "R2 g0 req to code3");
    step(1, 0, 0, 1, 0, 0, 0, 0, '0, "R3 ns level0 drop");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0001, "R6 write id0=1");
    step(1, 0, 0, 1, 0, 0, 0, 0, '0, "R3 ns level1 accept");
    step(1, 0, 1, 1, 0, 0, 0, 0, '0, "R3 ns downgrade level1");
    step(1, 1, 1, 1, 0, 0, 1, 1, 32'h0000_0004, "R4 ns level0 drop");
    step(1, 1, 1, 1, 0, 0, 0, 0, '0, "R4 ns level1 drop");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0008, "R6 write id1=2");
    step(1, 1, 1, 1, 0, 0, 0, 0, '0, "R4 ns level2 accept");
    step(1, 2, 1, 1, 0, 0, 0, 0, '0, "R5 ns1 target no level");
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R6 nonsecure write ignored");
    ds = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, "R6 ds write ignored");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0000, "R6 ds clear ignored");
    step(1, 1, 1, 1, 0, 0, 0, 0, '0, "R5 ds bypass");
    ds = 1'b0;
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0000, "R6 clear all");
    ds = 1'b1;
    step(1, 0, 0, 1, 0, 0, 0, 0, '0, "R5 ds g0 level0");
    ds = 1'b0;
    step(1, 1, 1, 0, 0, 0, 0, 0, '0, "R5 secure sec1 level0");
    step(0, 0, 0, 0, 1, 20, 0, 0, '0, "R8 ppi 20");
    step(1, 0, 1, 0, 1, 31, 0, 0, '0, "R8 ppi with sgi");
    step(0, 0, 0, 0, 1, 16, 0, 0, '0, "R8 ppi 16");
    step(0, 0, 0, 0, 1, 5, 0, 0, '0, "R9 ppi low id");
    step(1, 0, 1, 0, 1, 15, 0, 0, '0, "R9 low id with sgi");
    idle("R7 strobe clears");

    for (int n = 0; n < 3000; n++) begin
      if (n % 50 == 0) sgi_grp = $urandom;
      if (n % 17 == 0) ds = ($urandom % 4 == 0);
      step($urandom % 2, $urandom % 16, $urandom % 2, $urandom % 2,
           $urandom % 3 == 0, $urandom % 32, $urandom % 6 == 0,
           $urandom % 2, $urandom, "R1 R2 R3 R4 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule